// File: doc/BRIEF.md
# Motor Drive Power-Up and Shutdown Sequencer

This block is the supervisory state machine on the master side of a motor drive. It keeps the control processor in reset until the operator asks for a start. It then runs two parameter transfer phases with the processor and checks that the power stage reports healthy. Next it precharges the DC bus through a charging contactor for a programmed time and checks that the bus has charged. If so it hands the bus over to the main contactor and raises the run command bit that goes into the processor mailbox.

A stop command clears the run bit, puts the processor back into reset and opens every contactor. A protection trip does the same, but the block then stays in a latched fault state and reports a fault code until the operator clears it. The precharge time is a prescaler count times a tick count. The charge test compares the bus sample with four fifths of a rated-voltage input. The comparison is cross-multiplied, so no divider is needed.

Top module: `drive_sequencer`

## Requirements
- R1: During and after reset, proc_rst_n is 0, charge_close, main_close and run_bit are 0, xfer_phase is 0 and fault_code is 0 (no fault).
- R2: In the idle hold state a start_cmd seen at a clock edge releases proc_rst_n to 1 and sets xfer_phase to 1 (read back defaults) after that edge. A xfer_done then moves xfer_phase to 2 (send parameters). A second xfer_done moves it to 0 and enters the health check.
- R3: If healthy is 0 at the health check, fault_code becomes 1. From then on, whenever fault_code is nonzero, proc_rst_n, both contactor commands and run_bit are 0.
- R4: If healthy is 1 at the health check, charge_close is 1 with main_close 0 for exactly TICK_DIV*CHARGE_TICKS consecutive cycles.
- R5: At the end of precharge the bus counts as charged when 5*bus_sample >= 4*bus_rated. If it is charged, charge_close drops and main_close rises in the same cycle, and run_bit rises one cycle later. If it is not charged, fault_code becomes 2 and everything is off.
- R6: charge_close and main_close are never 1 together. run_bit is 1 only while main_close and proc_rst_n are 1.
- R7: stop_cmd without trip in any active state (proc_rst_n = 1) returns to hold on the next edge. After that edge all outputs are 0 and fault_code stays 0.
- R8: trip in any active state gives the same shutdown outputs but fault_code 3. When trip and stop_cmd arrive together, the trip wins.
- R9: A nonzero fault_code holds. In the fault state start_cmd, stop_cmd and trip are ignored, and only clear_fault returns to hold with fault_code 0.
- R10: In hold, stop_cmd, trip and clear_fault have no effect. Every output stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_cmd | input | 1 | Operator start request |
| stop_cmd | input | 1 | Operator stop request |
| clear_fault | input | 1 | Operator fault acknowledge |
| xfer_done | input | 1 | Current parameter transfer phase finished |
| healthy | input | 1 | Power stage reports healthy |
| trip | input | 1 | Protection trip |
| bus_sample | input | VW | DC bus voltage sample |
| bus_rated | input | VW | Rated DC bus voltage |
| proc_rst_n | output | 1 | Active-low reset to the control processor |
| charge_close | output | 1 | Close command for the charging contactor |
| main_close | output | 1 | Close command for the main contactor |
| run_bit | output | 1 | Run command bit for the processor mailbox |
| xfer_phase | output | 2 | 0 none, 1 read back defaults, 2 send parameters |
| fault_code | output | 2 | 0 none, 1 unhealthy, 2 bus not charged, 3 trip |

## Verification
The assertions take for granted that the command and status inputs are synchronous levels sampled at each edge. They also assume that bus_sample and bus_rated are valid in every cycle, because the charge decision reads them at the edge where the precharge window expires. The stimulus changes inputs only just after a clock edge and holds the bus values steady through each precharge. It picks random bus values close to the four-fifths boundary, random health and random idle gaps from a fixed seed. Directed cases cover the exact threshold, simultaneous stop and trip, and trips in the middle of a transfer or a precharge.

// File: rtl/drv_seq_pkg.sv
package drv_seq_pkg;

    typedef enum logic [2:0] {
        ST_HOLD      = 3'd0,
        ST_READBACK  = 3'd1,
        ST_SEND      = 3'd2,
        ST_HEALTH    = 3'd3,
        ST_PRECHARGE = 3'd4,
        ST_HANDOVER  = 3'd5,
        ST_RUN       = 3'd6,
        ST_FAULT     = 3'd7
    } seq_state_e;

    typedef enum logic [1:0] {
        FLT_NONE      = 2'd0,
        FLT_UNHEALTHY = 2'd1,
        FLT_LOWBUS    = 2'd2,
        FLT_TRIP      = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        XF_NONE     = 2'd0,
        XF_READBACK = 2'd1,
        XF_SEND     = 2'd2
    } xfer_e;

    typedef struct packed {
        seq_state_e state;
        fault_e     fault;
        logic       proc_rst_n;
        logic       charge;
        logic       main;
        logic       run;
        xfer_e      xfer;
    } seq_regs_t;

    localparam seq_regs_t SEQ_RESET = '{
        state:      ST_HOLD,
        fault:      FLT_NONE,
        proc_rst_n: 1'b0,
        charge:     1'b0,
        main:       1'b0,
        run:        1'b0,
        xfer:       XF_NONE
    };

    function automatic logic is_active(input seq_state_e s);
        return (s != ST_HOLD) && (s != ST_FAULT);
    endfunction

endpackage

// File: rtl/drv_seq_timer.sv
module drv_seq_timer #(
    parameter int unsigned TICK_DIV     = 100000,
    parameter int unsigned CHARGE_TICKS = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic expired
);
    localparam int CW = (CHARGE_TICKS > 1) ? $clog2(CHARGE_TICKS) : 1;
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic tick;
    logic [CW-1:0] cnt_d, cnt_q;

    generate
        if (TICK_DIV > 1) begin : g_pre
            logic [PW-1:0] pre_d, pre_q;
            logic          wrap;
            assign wrap = (pre_q == PW'(TICK_DIV - 1));
            always_comb begin
                pre_d = pre_q;
                if (!en)       pre_d = '0;
                else if (wrap) pre_d = '0;
                else           pre_d = pre_q + 1'b1;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pre_q <= '0;
                else        pre_q <= pre_d;
            end
            assign tick = en && wrap;
        end else begin : g_nopre
            assign tick = en;
        end
    endgenerate

    always_comb begin
        cnt_d = cnt_q;
        if (!en)       cnt_d = '0;
        else if (tick) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = tick && (cnt_q == CW'(CHARGE_TICKS - 1));

endmodule

// File: rtl/drv_seq_busmon.sv
module drv_seq_busmon #(
    parameter int unsigned VW = 12
) (
    input  logic [VW-1:0] bus_sample,
    input  logic [VW-1:0] bus_rated,
    output logic          charged
);
    localparam int XW = VW + 3;

    logic [XW-1:0] lhs;
    logic [XW-1:0] rhs;

    // sample >= 0.8 * rated, evaluated as 5*sample >= 4*rated
    always_comb begin
        lhs = {3'b000, bus_sample} * XW'(5);
        rhs = {1'b0, bus_rated, 2'b00};
        charged = (lhs >= rhs);
    end

endmodule

// File: rtl/drv_seq_fsm.sv
module drv_seq_fsm
    import drv_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_cmd,
    input  logic      stop_cmd,
    input  logic      clear_fault,
    input  logic      xfer_done,
    input  logic      healthy,
    input  logic      trip,
    input  logic      charged,
    input  logic      expired,
    output logic      timer_en,
    output seq_regs_t regs_q
);
    seq_regs_t regs_d;

    always_comb begin
        regs_d = regs_q;

        case (regs_q.state)
            ST_HOLD: begin
                if (start_cmd) regs_d.state = ST_READBACK;
            end
            ST_READBACK: begin
                if (xfer_done) regs_d.state = ST_SEND;
            end
            ST_SEND: begin
                if (xfer_done) regs_d.state = ST_HEALTH;
            end
            ST_HEALTH: begin
                if (healthy) begin
                    regs_d.state = ST_PRECHARGE;
                end else begin
                    regs_d.state = ST_FAULT;
                    regs_d.fault = FLT_UNHEALTHY;
                end
            end
            ST_PRECHARGE: begin
                if (expired) begin
                    if (charged) begin
                        regs_d.state = ST_HANDOVER;
                    end else begin
                        regs_d.state = ST_FAULT;
                        regs_d.fault = FLT_LOWBUS;
                    end
                end
            end
            ST_HANDOVER: begin
                regs_d.state = ST_RUN;
            end
            ST_RUN: begin
                regs_d.state = ST_RUN;
            end
            ST_FAULT: begin
                if (clear_fault) begin
                    regs_d.state = ST_HOLD;
                    regs_d.fault = FLT_NONE;
                end
            end
            default: begin
                regs_d.state = ST_HOLD;
                regs_d.fault = FLT_NONE;
            end
        endcase

        // shutdown requests override the normal progression
        if (is_active(regs_q.state)) begin
            if (trip) begin
                regs_d.state = ST_FAULT;
                regs_d.fault = FLT_TRIP;
            end else if (stop_cmd) begin
                regs_d.state = ST_HOLD;
                regs_d.fault = FLT_NONE;
            end
        end

        // registered output decode of the next state
        regs_d.proc_rst_n = is_active(regs_d.state);
        regs_d.charge     = (regs_d.state == ST_PRECHARGE);
        regs_d.main       = (regs_d.state == ST_HANDOVER) || (regs_d.state == ST_RUN);
        regs_d.run        = (regs_d.state == ST_RUN);
        case (regs_d.state)
            ST_READBACK: regs_d.xfer = XF_READBACK;
            ST_SEND:     regs_d.xfer = XF_SEND;
            default:     regs_d.xfer = XF_NONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= SEQ_RESET;
        else        regs_q <= regs_d;
    end

    assign timer_en = (regs_q.state == ST_PRECHARGE);

endmodule

// File: rtl/drive_sequencer.sv
module drive_sequencer
    import drv_seq_pkg::*;
#(
    parameter int unsigned TICK_DIV     = 100000,
    parameter int unsigned CHARGE_TICKS = 2000,
    parameter int unsigned VW           = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_cmd,
    input  logic          stop_cmd,
    input  logic          clear_fault,
    input  logic          xfer_done,
    input  logic          healthy,
    input  logic          trip,
    input  logic [VW-1:0] bus_sample,
    input  logic [VW-1:0] bus_rated,
    output logic          proc_rst_n,
    output logic          charge_close,
    output logic          main_close,
    output logic          run_bit,
    output logic [1:0]    xfer_phase,
    output logic [1:0]    fault_code
);
    logic      charged;
    logic      expired;
    logic      timer_en;
    seq_regs_t regs_q;

    drv_seq_busmon #(.VW(VW)) busmon_i (
        .bus_sample (bus_sample),
        .bus_rated  (bus_rated),
        .charged    (charged)
    );

    drv_seq_timer #(
        .TICK_DIV     (TICK_DIV),
        .CHARGE_TICKS (CHARGE_TICKS)
    ) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (timer_en),
        .expired (expired)
    );

    drv_seq_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_cmd   (start_cmd),
        .stop_cmd    (stop_cmd),
        .clear_fault (clear_fault),
        .xfer_done   (xfer_done),
        .healthy     (healthy),
        .trip        (trip),
        .charged     (charged),
        .expired     (expired),
        .timer_en    (timer_en),
        .regs_q      (regs_q)
    );

    assign proc_rst_n   = regs_q.proc_rst_n;
    assign charge_close = regs_q.charge;
    assign main_close   = regs_q.main;
    assign run_bit      = regs_q.run;
    assign xfer_phase   = regs_q.xfer;
    assign fault_code   = regs_q.fault;

endmodule

// File: rtl/drive_sequencer_chk.sv
module drive_sequencer_chk #(
    parameter int unsigned TICK_DIV     = 100000,
    parameter int unsigned CHARGE_TICKS = 2000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_cmd,
    input logic       stop_cmd,
    input logic       clear_fault,
    input logic       trip,
    input logic       proc_rst_n,
    input logic       charge_close,
    input logic       main_close,
    input logic       run_bit,
    input logic [1:0] xfer_phase,
    input logic [1:0] fault_code
);
    localparam logic [63:0] WINDOW = 64'(TICK_DIV) * 64'(CHARGE_TICKS);

    logic [63:0] charge_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            charge_len_q <= '0;
        else if (charge_close) charge_len_q <= charge_len_q + 64'd1;
        else                   charge_len_q <= '0;
    end

    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_rst_n && fault_code == 2'd0 && start_cmd) |=> (proc_rst_n && xfer_phase == 2'd1));

    p_fault_safe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code != 2'd0) |-> (!proc_rst_n && !charge_close && !main_close && !run_bit));

    p_charge_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        charge_close |-> (charge_len_q < WINDOW && !main_close));

    p_handover_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (main_close && !run_bit && !stop_cmd && !trip) |=> run_bit);

    p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(charge_close && main_close));

    p_run_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run_bit |-> (main_close && proc_rst_n));

    p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_rst_n && stop_cmd && !trip) |=>
        (fault_code == 2'd0 && !proc_rst_n && !charge_close && !main_close && !run_bit && xfer_phase == 2'd0));

    p_trip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_rst_n && trip) |=>
        (fault_code == 2'd3 && !proc_rst_n && !charge_close && !main_close && !run_bit));

    p_fault_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code != 2'd0 && !clear_fault) |=> ($stable(fault_code) && !proc_rst_n));

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code != 2'd0 && clear_fault) |=> (fault_code == 2'd0 && !proc_rst_n));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_rst_n && fault_code == 2'd0 && !start_cmd) |=> (!proc_rst_n && fault_code == 2'd0));

endmodule

bind drive_sequencer drive_sequencer_chk #(
    .TICK_DIV     (TICK_DIV),
    .CHARGE_TICKS (CHARGE_TICKS)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_cmd    (start_cmd),
    .stop_cmd     (stop_cmd),
    .clear_fault  (clear_fault),
    .trip         (trip),
    .proc_rst_n   (proc_rst_n),
    .charge_close (charge_close),
    .main_close   (main_close),
    .run_bit      (run_bit),
    .xfer_phase   (xfer_phase),
    .fault_code   (fault_code)
);

// File: tb/drive_sequencer_tb_top.sv
module drive_sequencer_tb_top;
    localparam int TD   = 4;
    localparam int CT   = 5;
    localparam int VW   = 12;
    localparam int WAIT = TD * CT;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          start_cmd = 1'b0, stop_cmd = 1'b0, clear_fault = 1'b0;
    logic          xfer_done = 1'b0, healthy = 1'b0, trip = 1'b0;
    logic [VW-1:0] bus_sample = '0, bus_rated = '0;
    logic          proc_rst_n, charge_close, main_close, run_bit;
    logic [1:0]    xfer_phase, fault_code;

    drive_sequencer #(.TICK_DIV(TD), .CHARGE_TICKS(CT), .VW(VW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
        .clear_fault(clear_fault), .xfer_done(xfer_done), .healthy(healthy),
        .trip(trip), .bus_sample(bus_sample), .bus_rated(bus_rated),
        .proc_rst_n(proc_rst_n), .charge_close(charge_close), .main_close(main_close),
        .run_bit(run_bit), .xfer_phase(xfer_phase), .fault_code(fault_code)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_off(input string tag, input int code);
        chk_eq({tag, " proc_rst_n"}, int'(proc_rst_n), 0);
        chk_eq({tag, " charge"}, int'(charge_close), 0);
        chk_eq({tag, " main"}, int'(main_close), 0);
        chk_eq({tag, " run"}, int'(run_bit), 0);
        chk_eq({tag, " xfer"}, int'(xfer_phase), 0);
        chk_eq({tag, " fault"}, int'(fault_code), code);
    endtask

    function automatic bit exp_ok(input int s, input int r);
        return (5 * s) >= (4 * r);
    endfunction

    task automatic to_health(input int idle);
        start_cmd = 1'b1;
        step();
        start_cmd = 1'b0;
        chk_eq("R2 release proc", int'(proc_rst_n), 1);
        chk_eq("R2 readback phase", int'(xfer_phase), 1);
        for (int i = 0; i < idle; i++) step();
        chk_eq("R2 readback waits", int'(xfer_phase), 1);
        xfer_done = 1'b1;
        step();
        chk_eq("R2 send phase", int'(xfer_phase), 2);
        step();
        xfer_done = 1'b0;
        chk_eq("R2 health phase", int'(xfer_phase), 0);
        chk_eq("R2 no charge yet", int'(charge_close), 0);
    endtask

    // returns 1 when the drive reached run
    task automatic attempt(input bit h, input int s, input int r, input int idle, output bit ran);
        int len;
        bit main_seen;
        ran = 1'b0;
        bus_sample = VW'(s);
        bus_rated  = VW'(r);
        healthy    = h;
        to_health(idle);
        step();
        if (!h) begin
            chk_off("R3 unhealthy", 1);
            return;
        end
        len = 0;
        main_seen = 1'b0;
        while (charge_close && len < 1000) begin
            if (main_close) main_seen = 1'b1;
            len++;
            step();
        end
        chk_eq("R4 precharge length", len, WAIT);
        chk_eq("R6 main open in precharge", int'(main_seen), 0);
        if (exp_ok(s, r)) begin
            chk_eq("R5 handover charge", int'(charge_close), 0);
            chk_eq("R5 handover main", int'(main_close), 1);
            chk_eq("R5 handover run", int'(run_bit), 0);
            step();
            chk_eq("R5 run bit", int'(run_bit), 1);
            chk_eq("R6 run with main", int'(main_close), 1);
            chk_eq("R6 run with proc", int'(proc_rst_n), 1);
            ran = 1'b1;
        end else begin
            chk_off("R5 bus low", 2);
        end
    endtask

    task automatic do_stop();
        stop_cmd = 1'b1; step(); stop_cmd = 1'b0;
        chk_off("R7 stop", 0);
    endtask

    task automatic do_trip();
        trip = 1'b1; step(); trip = 1'b0;
        chk_off("R8 trip", 3);
    endtask

    task automatic do_clear();
        clear_fault = 1'b1; step(); clear_fault = 1'b0;
        chk_off("R9 clear", 0);
    endtask

    initial begin
        bit ran;
        int r, s;
        void'($urandom(32'd20240607));

        repeat (3) step();
        chk_off("R1 in reset", 0);
        rst_n = 1'b1;
        step();
        chk_off("R1 after reset", 0);

        // R10: hold ignores stop, trip and clear
        stop_cmd = 1'b1; trip = 1'b1; clear_fault = 1'b1;
        step();
        stop_cmd = 1'b0; trip = 1'b0; clear_fault = 1'b0;
        step();
        chk_off("R10 hold ignores", 0);

        // exact threshold: 800 of 1000 charges, 799 does not
        attempt(1'b1, 800, 1000, 1, ran);
        chk_eq("R5 exact threshold ran", int'(ran), 1);
        repeat (3) step();
        chk_eq("R5 run persists", int'(run_bit), 1);
        do_stop();

        attempt(1'b1, 799, 1000, 0, ran);
        chk_eq("R5 below threshold ran", int'(ran), 0);
        start_cmd = 1'b1; step(); start_cmd = 1'b0;
        chk_off("R9 start ignored in fault", 2);
        stop_cmd = 1'b1; trip = 1'b1; step(); stop_cmd = 1'b0; trip = 1'b0;
        chk_off("R9 stop and trip ignored in fault", 2);
        do_clear();

        // rated 1001: 801 charges, 800 does not
        attempt(1'b1, 801, 1001, 2, ran);
        chk_eq("R5 rated 1001 s801", int'(ran), 1);
        stop_cmd = 1'b1; trip = 1'b1; step(); stop_cmd = 1'b0; trip = 1'b0;
        chk_off("R8 trip beats stop", 3);
        do_clear();

        attempt(1'b1, 800, 1001, 0, ran);
        chk_eq("R5 rated 1001 s800", int'(ran), 0);
        do_clear();

        attempt(1'b0, 900, 1000, 0, ran);
        do_clear();

        // stop during readback
        start_cmd = 1'b1; step(); start_cmd = 1'b0;
        stop_cmd = 1'b1; step(); stop_cmd = 1'b0;
        chk_off("R7 stop in readback", 0);

        // trip during send phase
        start_cmd = 1'b1; step(); start_cmd = 1'b0;
        xfer_done = 1'b1; step(); xfer_done = 1'b0;
        do_trip();
        do_clear();

        // trip during precharge
        healthy = 1'b1; bus_sample = 12'd1000; bus_rated = 12'd1000;
        to_health(0);
        step();
        chk_eq("R4 precharge entered", int'(charge_close), 1);
        repeat (5) step();
        do_trip();
        do_clear();

        // stop during precharge
        to_health(1);
        step();
        repeat (3) step();
        do_stop();

        // random trials near the threshold
        for (int t = 0; t < 40; t++) begin
            r = int'($urandom_range(4095, 50));
            s = (r * 4) / 5 + int'($urandom_range(6, 0)) - 3;
            if (s < 0) s = 0;
            if (s > 4095) s = 4095;
            attempt(($urandom_range(7, 0) != 0), s, r, int'($urandom_range(3, 0)), ran);
            if (ran) begin
                repeat (int'($urandom_range(5, 0))) step();
                chk_eq("R5 random run holds", int'(run_bit), 1);
                if ($urandom_range(1, 0) == 0) do_stop();
                else begin
                    do_trip();
                    do_clear();
                end
            end else begin
                do_clear();
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule